// File: doc/BRIEF.md
# Conversion-Ready Timing Sequencer

This controller sits beside a filtered sigma-delta converter and decides when the filter output can be trusted. It counts pulses of a modulator sample-rate enable. When a counted interval completes, it latches the converter's result word, strobes a one-cycle latch pulse and drops an active-low ready flag. Any channel selection, or any start of conversion, first requires a long filter settling interval. While the channel stays the same, later results come at a shorter interval. Ready stays inactive for the whole settling interval, so a host that waits for ready low only ever reads valid data.

The interval lengths depend on an 8-bit filter word and a chop-enable bit. A 3-bit mode code selects idle, continuous or single conversion, and a mode write strobe loads it. A channel write strobe marks a change of input channel.

The sequencer has three states:
- IDLE: the timer is held cleared and no results are produced.
- SETTLE: counting toward the first result.
- STREAM: counting toward later results.

The transitions are:
- start (IDLE to SETTLE): a valid mode is pending and the filter word is valid.
- restart (SETTLE or STREAM to SETTLE): a channel write or a mode write with a start code.
- first-result (SETTLE to STREAM): continuous mode.
- single-done (SETTLE to IDLE): single mode. The stored mode also becomes idle.
- abort (any state to IDLE): the filter word becomes invalid, or an idle or unknown code is written.

Top module: `conv_ready_seq`

## Requirements
- R1: A filter word below 3 is invalid. While it is invalid the sequencer goes to IDLE and produces no results. A pending continuous or single mode starts a fresh settling interval once the word is valid again.
- R2: With chop off, the first result after a start or channel write completes on the 24×SF-th counted sample tick.
- R3: With chop off and no channel write, each later result completes 8×SF sample ticks after the previous one.
- R4: With chop on, the first result after a start or channel write completes on the 48×SF-th counted sample tick. The same applies to single mode.
- R5: With chop on and no channel write, each later result completes 24×SF sample ticks after the previous one.
- R6: A channel write while converting restarts the settling count and forces ready high on the next cycle. Ready stays high until the full settling interval has elapsed. A channel write in the same cycle as a completing tick discards that result.
- R7: On the clock after a completing tick, latch_stb is high for one cycle, rdy_n is low, and dout holds the din value sampled with that tick. Ready never falls without latch_stb.
- R8: Ready returns high one clock after rd_ack. In continuous mode it also returns high on the first sample tick after a result, whichever comes first.
- R9: Writing mode code 3'b010 (single) starts one settling interval. That interval yields exactly one result, then the sequencer returns to IDLE. Ready stays low until acknowledged.
- R10: Mode code 3'b000 (idle), and every code other than 3'b001 (continuous) and 3'b010, produces no results. In IDLE a channel write has no effect on ready.
- R11: After reset, rdy_n is 1, latch_stb is 0, dout is 0 and the sequencer is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-cycle modulator sample-rate enable |
| filt_word | input | SF_W | Filter word SF (valid 3..255) |
| chop_en | input | 1 | Chop enable, selects the longer intervals |
| mode_code | input | 3 | Mode value loaded by mode_wr |
| mode_wr | input | 1 | Mode write strobe |
| chan_wr | input | 1 | Channel select write strobe |
| rd_ack | input | 1 | Host read acknowledge |
| din | input | DATA_W | Converter result word |
| rdy_n | output | 1 | Active-low result ready |
| latch_stb | output | 1 | One-cycle pulse when dout is updated |
| dout | output | DATA_W | Latched result |

## Verification
Two events can meet in one clock: the sample tick that completes an interval, and a channel write. The bench drives both in the same cycle, after exactly one tick fewer than the settling length. It then expects no latch strobe, ready held high, and a new full settling interval before the next result. A read acknowledge that lands with a completing tick is resolved the same way, with the new result taking priority. Continuous-mode release of ready by the next tick is judged on the tick right after each result.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_STREAM = 2'd2
    } seq_state_t;

    localparam logic [2:0] MODE_IDLE   = 3'b000;
    localparam logic [2:0] MODE_CONT   = 3'b001;
    localparam logic [2:0] MODE_SINGLE = 3'b010;

    localparam int SF_MIN = 3;

    localparam int MULT_FIRST_PLAIN = 24;
    localparam int MULT_NEXT_PLAIN  = 8;
    localparam int MULT_FIRST_CHOP  = 48;
    localparam int MULT_NEXT_CHOP   = 24;

    function automatic logic mode_runs(input logic [2:0] m);
        return (m == MODE_CONT) || (m == MODE_SINGLE);
    endfunction
endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    assign hit = en && !clr && (cnt >= limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= hit ? '0 : cnt + CNT_W'(1);
        end
    end

    // R3
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !hit) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    // R7
    timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cnt == '0);
endmodule

// File: rtl/result_latch.sv
module result_latch #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              stb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
            stb  <= 1'b0;
        end else begin
            stb <= capture;
            if (capture) dout <= din;
        end
    end

    // R7
    latch_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (stb && dout == $past(din)));
endmodule

// File: rtl/conv_ready_seq.sv
module conv_ready_seq
    import conv_seq_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int SF_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_tick,
    input  logic [SF_W-1:0]   filt_word,
    input  logic              chop_en,
    input  logic [2:0]        mode_code,
    input  logic              mode_wr,
    input  logic              chan_wr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] din,
    output logic              rdy_n,
    output logic              latch_stb,
    output logic [DATA_W-1:0] dout
);
    localparam int CNT_W = SF_W + 6;

    seq_state_t       st_q, st_d;
    logic [2:0]       mode_q, mode_d;
    logic             sf_ok, running, tmr_clr, tmr_en, tmr_hit;
    logic [CNT_W-1:0] mult, limit;

    assign sf_ok   = filt_word >= SF_W'(SF_MIN);
    assign running = (st_q != ST_IDLE);
    assign tmr_clr = mode_wr || !running || !sf_ok || chan_wr;
    assign tmr_en  = smp_tick && running;

    always_comb begin
        if (st_q == ST_SETTLE)
            mult = chop_en ? CNT_W'(MULT_FIRST_CHOP) : CNT_W'(MULT_FIRST_PLAIN);
        else
            mult = chop_en ? CNT_W'(MULT_NEXT_CHOP) : CNT_W'(MULT_NEXT_PLAIN);
        limit = mult * {{(CNT_W-SF_W){1'b0}}, filt_word};
    end

    interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .limit (limit),
        .hit   (tmr_hit)
    );

    result_latch #(.DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (tmr_hit),
        .din     (din),
        .dout    (dout),
        .stb     (latch_stb)
    );

    // next-state logic
    always_comb begin
        st_d   = st_q;
        mode_d = mode_q;
        if (mode_wr) begin
            mode_d = mode_code;
            st_d   = (mode_runs(mode_code) && sf_ok) ? ST_SETTLE : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (sf_ok && mode_runs(mode_q)) st_d = ST_SETTLE;
                end
                ST_SETTLE, ST_STREAM: begin
                    if (!sf_ok) begin
                        st_d = ST_IDLE;
                    end else if (chan_wr) begin
                        st_d = ST_SETTLE;
                    end else if (tmr_hit) begin
                        if (mode_q == MODE_SINGLE) begin
                            st_d   = ST_IDLE;
                            mode_d = MODE_IDLE;
                        end else begin
                            st_d = ST_STREAM;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= MODE_IDLE;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_n <= 1'b1;
        end else if (mode_wr || (running && chan_wr)) begin
            rdy_n <= 1'b1;
        end else if (tmr_hit) begin
            rdy_n <= 1'b0;
        end else if (rd_ack) begin
            rdy_n <= 1'b1;
        end else if (smp_tick && running) begin
            rdy_n <= 1'b1;
        end
    end

    // R7
    rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> latch_stb);

    // R1
    bad_sf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_ok |=> st_q == ST_IDLE);

    // R6
    chan_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && chan_wr) |=> (rdy_n && !latch_stb));

    // R9
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_hit && mode_q == MODE_SINGLE && !mode_wr && !chan_wr)
            |=> (st_q == ST_IDLE && mode_q == MODE_IDLE));

    // R10
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !mode_runs(mode_code)) |=> (st_q == ST_IDLE && !tmr_hit));
endmodule

// File: tb/conv_ready_seq_test.sv
`timescale 1ns/1ps
module conv_ready_seq_test;
    localparam int DATA_W = 24;
    localparam int SF_W   = 8;

    // sf, chop, first interval, later interval
    localparam int VEC [0:4][0:3] = '{
        '{3,   0, 72,   24},
        '{10,  1, 480,  240},
        '{5,   0, 120,  40},
        '{4,   1, 192,  96},
        '{255, 0, 6120, 2040}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_tick = 1'b0;
    logic [SF_W-1:0]   filt_word = 8'd3;
    logic              chop_en = 1'b0;
    logic [2:0]        mode_code = 3'b000;
    logic              mode_wr = 1'b0;
    logic              chan_wr = 1'b0;
    logic              rd_ack = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              rdy_n;
    logic              latch_stb;
    logic [DATA_W-1:0] dout;

    int n_chk = 0;
    int n_bad = 0;
    int low_cnt = 0;
    int stb_cnt = 0;

    always #2.5 clk = ~clk;

    conv_ready_seq #(.DATA_W(DATA_W), .SF_W(SF_W)) uut (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .filt_word(filt_word),
        .chop_en(chop_en), .mode_code(mode_code), .mode_wr(mode_wr),
        .chan_wr(chan_wr), .rd_ack(rd_ack), .din(din),
        .rdy_n(rdy_n), .latch_stb(latch_stb), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick(output bit got);
        logic [DATA_W-1:0] exp_d;
        @(negedge clk);
        smp_tick = 1'b1;
        din = din * 24'd5 + 24'h1357;
        exp_d = din;
        @(negedge clk);
        smp_tick = 1'b0;
        got = latch_stb;
        if (got) begin
            stb_cnt++;
            check(dout == exp_d, "R7 dout", int'(dout), int'(exp_d));
            check(rdy_n == 1'b0, "R7 rdy_n low", int'(rdy_n), 0);
        end else if (!rdy_n) begin
            low_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic run_until(input int max, output int n);
        bit g;
        n = 0;
        for (int i = 1; i <= max; i++) begin
            do_tick(g);
            if (g) begin
                n = i;
                return;
            end
        end
    endtask

    task automatic run_n(input int cnt);
        bit g;
        for (int i = 0; i < cnt; i++) do_tick(g);
    endtask

    task automatic pulse_mode(input logic [2:0] code);
        @(negedge clk);
        mode_code = code;
        mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic pulse_chan();
        @(negedge clk);
        chan_wr = 1'b1;
        @(negedge clk);
        chan_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    initial begin
        #(5.0 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        bit g;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(rdy_n == 1'b1, "R11 rdy_n", int'(rdy_n), 1);
        check(latch_stb == 1'b0, "R11 latch_stb", int'(latch_stb), 0);
        check(dout == '0, "R11 dout", int'(dout), 0);
        rst_n = 1'b1;
        run_n(5);
        check(stb_cnt == 0, "R11 idle after reset", stb_cnt, 0);

        // table walk: first and later interval, continuous mode
        for (int v = 0; v < 5; v++) begin
            filt_word = SF_W'(VEC[v][0]);
            chop_en   = VEC[v][1][0];
            pulse_mode(3'b001);
            low_cnt = 0;
            run_until(VEC[v][2] + 5, n);
            check(n == VEC[v][2], chop_en ? "R4 first" : "R2 first", n, VEC[v][2]);
            check(low_cnt == 0, "R6 ready held in settle", low_cnt, 0);
            do_tick(g);
            check(rdy_n == 1'b1 && !g, "R8 tick release", int'(rdy_n), 1);
            run_until(VEC[v][3] + 5, n);
            check(n == VEC[v][3] - 1, chop_en ? "R5 next" : "R3 next", n + 1, VEC[v][3]);
        end

        // R6 channel write mid-conversion
        filt_word = 8'd3;
        chop_en = 1'b0;
        pulse_mode(3'b001);
        stb_cnt = 0;
        run_n(30);
        pulse_chan();
        low_cnt = 0;
        run_until(100, n);
        check(n == 72 && stb_cnt == 1, "R6 restart length", n, 72);
        check(low_cnt == 0, "R6 no early ready", low_cnt, 0);

        // R6 channel write in the same cycle as the completing tick
        pulse_chan();
        check(rdy_n == 1'b1, "R6 chan sets rdy high", int'(rdy_n), 1);
        stb_cnt = 0;
        run_n(71);
        @(negedge clk);
        smp_tick = 1'b1;
        chan_wr = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
        chan_wr = 1'b0;
        check(!latch_stb && rdy_n && stb_cnt == 0, "R6 collision discards", int'(latch_stb), 0);
        @(negedge clk);
        run_until(100, n);
        check(n == 72, "R6 collision restart", n, 72);

        // R1 invalid filter word
        pulse_ack();
        filt_word = 8'd2;
        pulse_mode(3'b001);
        stb_cnt = 0;
        run_n(150);
        check(stb_cnt == 0, "R1 sf=2 no results", stb_cnt, 0);
        filt_word = 8'd3;
        run_until(100, n);
        check(n == 72, "R1 resume after valid", n, 72);
        run_n(10);
        filt_word = 8'd1;
        stb_cnt = 0;
        run_n(100);
        check(stb_cnt == 0, "R1 abort on invalid", stb_cnt, 0);
        filt_word = 8'd3;

        // R10 idle and unknown codes
        pulse_mode(3'b101);
        stb_cnt = 0;
        run_n(150);
        check(stb_cnt == 0, "R10 code 101 idle", stb_cnt, 0);
        pulse_mode(3'b000);
        run_n(150);
        check(stb_cnt == 0, "R10 code 000 idle", stb_cnt, 0);

        // R9 single, chopped
        filt_word = 8'd4;
        chop_en = 1'b1;
        pulse_mode(3'b010);
        run_until(300, n);
        check(n == 192, "R9 R4 single chopped", n, 192);
        stb_cnt = 0;
        run_n(250);
        check(stb_cnt == 0, "R9 one result only", stb_cnt, 0);
        check(rdy_n == 1'b0, "R9 ready held low", int'(rdy_n), 0);
        pulse_chan();
        check(rdy_n == 1'b0, "R10 chan in idle ignored", int'(rdy_n), 0);
        pulse_ack();
        check(rdy_n == 1'b1, "R8 ack release", int'(rdy_n), 1);

        // R9 single, unchopped
        filt_word = 8'd3;
        chop_en = 1'b0;
        pulse_mode(3'b010);
        run_until(100, n);
        check(n == 72, "R9 R2 single plain", n, 72);

        // R11 reset mid-run
        pulse_mode(3'b001);
        run_n(20);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(rdy_n && !latch_stb && dout == '0, "R11 reset mid-run", int'(rdy_n), 1);
        rst_n = 1'b1;
        stb_cnt = 0;
        run_n(100);
        check(stb_cnt == 0, "R11 idle after reset", stb_cnt, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule